// File: doc/BRIEF.md
# UART Interrupt Ranking and Identification

This block sits beside the receive and transmit paths of a 16550-style serial port. It gathers five interrupt causes: line errors, receive data level, receive idle timeout, transmit empty and modem line change. Each cause has its own enable. The block ranks the enabled causes and presents the most urgent one as an 8-bit identification value, together with a single interrupt request line.

Each latched cause is cleared as a side effect of the register access that services it. The receive data cause follows the FIFO level, so it has no latch. The idle timeout is counted in character times, using a tick supplied by the baud logic. The FIFO storage, the shifters and the baud generator live elsewhere. They supply levels, push and pop strobes and the tick. The host bus decoder supplies one strobe per serviced access.

Top module: `uart_irq_ident`

## Requirements
- R1: Bits [3:0] of `iir` show the highest enabled pending cause, ranked line error (0110) above receive data (0100), receive data above receive timeout (1100), receive timeout above transmit empty (0010), and transmit empty above modem change (0000). The value 0001 means that nothing is pending.
- R2: Reset gives `iir` = 0x01 and `irq` = 0. At all times `iir[0]` is the inverse of `irq`. A cause raised by a strobe is visible two clock edges after that strobe is sampled. A change in the level inputs is visible after one edge.
- R3: `iir[7:6]` reads 11 when `fifo_en` is 1 and 00 when it is 0. `iir[5:4]` always reads 0. With `fifo_en` at 0, the timeout code never appears and bit 3 stays 0.
- R4: `ls_evt` latches the line cause and `rd_lsr` clears it. A set and a clear in the same cycle leave the cause set.
- R5: With `fifo_en` at 1, the receive data cause is active while `rx_level` is nonzero and `rx_level` >= `rx_thresh`. With `fifo_en` at 0, it follows `rx_full`.
- R6: With `fifo_en` at 1 and `rx_level` nonzero, the timeout cause is latched after TO_CHARS `char_tick` pulses with no `rx_push` or `rd_rxd` in between. Each push or pop restarts the count. An empty FIFO holds the count at zero. `rd_rxd` clears the cause.
- R7: `tx_empty_evt` latches the transmit cause and `wr_txd` clears it.
- R8: A read of `rd_iir` clears the transmit cause only if the `iir` value seen during that read shows 0010. Otherwise the transmit cause stays pending.
- R9: The modem cause is latched by any change on `cts`, `dsr` or `dcd`, and by a 1-to-0 change on `ri`. A 0-to-1 change on `ri` has no effect. `rd_msr` clears the cause.
- R10: The enable bits in `ien` are: bit 0 receive data, bit 1 transmit, bit 2 line, bit 3 modem, bit 4 timeout. An event that arrives while its enable is 0 is dropped. A latched cause whose enable is 0 does not show in `iir` or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO mode selected |
| ien | input | 5 | Per-cause enables |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_thresh | input | LVL_W | Receive level trigger |
| rx_full | input | 1 | Holding register full (non-FIFO mode) |
| rx_push | input | 1 | A character entered the receive FIFO |
| rd_rxd | input | 1 | Host read of the receive data port |
| char_tick | input | 1 | One pulse per character time |
| ls_evt | input | 1 | Parity, framing, overrun or break seen |
| tx_empty_evt | input | 1 | Transmit holding or FIFO became empty |
| wr_txd | input | 1 | Host write of the transmit data port |
| rd_lsr | input | 1 | Host read of line status |
| rd_msr | input | 1 | Host read of modem status |
| rd_iir | input | 1 | Host read of the identification value |
| cts | input | 1 | Clear-to-send line |
| dsr | input | 1 | Data-set-ready line |
| dcd | input | 1 | Carrier-detect line |
| ri | input | 1 | Ring indicator line |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the conditional clear on an identification read. It needs a transmit cause that is pending but hidden under a line error while the read happens. After that, a second read must find the transmit cause on top. The stimulus raises both causes, reads once with the line code shown, clears the line cause, and only then reads again. The timeout is also hard to reach, because it needs an exact number of ticks with no FIFO traffic. Directed runs of three and four ticks, split by a push, test the restart. A long random phase is then checked cycle by cycle against a behavioural model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] ID_NONE   = 4'b0001;
  localparam logic [3:0] ID_LINE   = 4'b0110;
  localparam logic [3:0] ID_RXDATA = 4'b0100;
  localparam logic [3:0] ID_RXTO   = 4'b1100;
  localparam logic [3:0] ID_TX     = 4'b0010;
  localparam logic [3:0] ID_MODEM  = 4'b0000;

  localparam int NSRC      = 5;
  localparam int EN_RXDATA = 0;
  localparam int EN_TX     = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;
  localparam int EN_RXTO   = 4;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic rxto;
    logic tx;
    logic modem;
  } src_t;
endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TO_CHARS = 4,
  parameter int LVL_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             enable,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rd_rxd,
  input  logic             char_tick,
  output logic             pend
);
  localparam int CW = $clog2(TO_CHARS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);
  localparam logic [CW-1:0] LAST  = CW'(TO_CHARS - 1);

  logic [CW-1:0] cnt;
  logic          restart, fire;

  assign restart = !fifo_en || (rx_level == '0) || rx_push || rd_rxd;
  assign fire    = !restart && char_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (restart) cnt <= '0;
      else if (char_tick && cnt != LIMIT) cnt <= cnt + 1'b1;

      if (fire && enable) pend <= 1'b1;
      else if (rd_rxd || !fifo_en) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ien,
  input  logic            ls_evt,
  input  logic            rd_lsr,
  input  logic            tx_empty_evt,
  input  logic            wr_txd,
  input  logic            rd_iir,
  input  logic            tx_on_top,
  input  logic            rd_msr,
  input  logic            cts,
  input  logic            dsr,
  input  logic            dcd,
  input  logic            ri,
  output logic            line_q,
  output logic            tx_q,
  output logic            modem_q
);
  localparam int NLATCH = 3;

  logic [3:0]        lines_q;
  logic              modem_chg;
  logic [NLATCH-1:0] set_v, clr_v, pend_v;

  always_ff @(posedge clk) begin
    if (rst) lines_q <= {cts, dsr, dcd, ri};
    else     lines_q <= {cts, dsr, dcd, ri};
  end

  // level change on three lines, trailing edge only on ring
  assign modem_chg = (cts ^ lines_q[3]) | (dsr ^ lines_q[2]) |
                     (dcd ^ lines_q[1]) | (lines_q[0] & ~ri);

  assign set_v = {modem_chg & ien[EN_MODEM],
                  tx_empty_evt & ien[EN_TX],
                  ls_evt & ien[EN_LINE]};
  assign clr_v = {rd_msr,
                  wr_txd | (rd_iir & tx_on_top),
                  rd_lsr};

  for (genvar i = 0; i < NLATCH; i++) begin : g_latch
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (set_v[i]) q <= 1'b1;
      else if (clr_v[i]) q <= 1'b0;
    end
    assign pend_v[i] = q;
  end

  assign line_q  = pend_v[0];
  assign tx_q    = pend_v[1];
  assign modem_q = pend_v[2];
endmodule

// File: rtl/uart_irq_rank.sv
module uart_irq_rank
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_en,
  input  src_t       act,
  output logic [7:0] iir,
  output logic       irq
);
  logic [3:0] code;

  always_comb begin
    if (act.line)        code = ID_LINE;
    else if (act.rxdata) code = ID_RXDATA;
    else if (act.rxto)   code = ID_RXTO;
    else if (act.tx)     code = ID_TX;
    else if (act.modem)  code = ID_MODEM;
    else                 code = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir <= {4'b0000, ID_NONE};
      irq <= 1'b0;
    end else begin
      iir <= {{2{fifo_en}}, 2'b00, code};
      irq <= |act;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TO_CHARS   = 4,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [NSRC-1:0]  ien,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             rx_full,
  input  logic             rx_push,
  input  logic             rd_rxd,
  input  logic             char_tick,
  input  logic             ls_evt,
  input  logic             tx_empty_evt,
  input  logic             wr_txd,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             rd_iir,
  input  logic             cts,
  input  logic             dsr,
  input  logic             dcd,
  input  logic             ri,
  output logic [7:0]       iir,
  output logic             irq
);
  logic line_q, tx_q, modem_q, rxto_q;
  logic rx_cond, tx_on_top;
  src_t act;

  assign rx_cond   = fifo_en ? ((rx_level != '0) && (rx_level >= rx_thresh)) : rx_full;
  assign tx_on_top = (iir[3:0] == ID_TX);

  uart_irq_sources u_src (
    .clk(clk), .rst(rst), .ien(ien),
    .ls_evt(ls_evt), .rd_lsr(rd_lsr),
    .tx_empty_evt(tx_empty_evt), .wr_txd(wr_txd),
    .rd_iir(rd_iir), .tx_on_top(tx_on_top), .rd_msr(rd_msr),
    .cts(cts), .dsr(dsr), .dcd(dcd), .ri(ri),
    .line_q(line_q), .tx_q(tx_q), .modem_q(modem_q)
  );

  uart_irq_timeout #(.TO_CHARS(TO_CHARS), .LVL_W(LVL_W)) u_to (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .enable(ien[EN_RXTO]),
    .rx_level(rx_level), .rx_push(rx_push), .rd_rxd(rd_rxd),
    .char_tick(char_tick), .pend(rxto_q)
  );

  assign act.line   = line_q  & ien[EN_LINE];
  assign act.rxdata = rx_cond & ien[EN_RXDATA];
  assign act.rxto   = rxto_q  & ien[EN_RXTO] & fifo_en;
  assign act.tx     = tx_q    & ien[EN_TX];
  assign act.modem  = modem_q & ien[EN_MODEM];

  uart_irq_rank u_rank (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .act(act),
    .iir(iir), .irq(irq)
  );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic       fifo_en,
  input logic [4:0] ien,
  input logic [7:0] iir,
  input logic       irq
);
  p_reset_state_r2: assert property (@(posedge clk)
    rst |=> (iir == 8'h01 && !irq));

  p_flag_vs_irq_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (iir[0] == !irq));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (iir[5:4] == 2'b00));

  p_fifo_bits_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_en |=> (iir[7:6] == 2'b11));

  p_nofifo_no_to_r3: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> (iir[7:6] == 2'b00 && !iir[3]));

  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (iir[3:0] inside {4'b0001, 4'b0110, 4'b0100,
                                      4'b1100, 4'b0010, 4'b0000}));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (ien == 5'b00000) |=> !irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .ien(ien), .iir(iir), .irq(irq)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int LVL_W = 5;
  localparam int TO_N  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0;
  logic [4:0] ien = 5'h1F;
  logic [LVL_W-1:0] rx_level = '0, rx_thresh = 5'd4;
  logic rx_full = 0, rx_push = 0, rd_rxd = 0, char_tick = 0, ls_evt = 0;
  logic tx_empty_evt = 0, wr_txd = 0, rd_lsr = 0, rd_msr = 0, rd_iir = 0;
  logic cts = 0, dsr = 0, dcd = 0, ri = 0;
  logic [7:0] iir;
  logic irq;

  int checks = 0, failures = 0;
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ien(ien),
    .rx_level(rx_level), .rx_thresh(rx_thresh), .rx_full(rx_full),
    .rx_push(rx_push), .rd_rxd(rd_rxd), .char_tick(char_tick),
    .ls_evt(ls_evt), .tx_empty_evt(tx_empty_evt), .wr_txd(wr_txd),
    .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_iir(rd_iir),
    .cts(cts), .dsr(dsr), .dcd(dcd), .ri(ri), .iir(iir), .irq(irq)
  );

  // behavioural reference
  bit m_line, m_tx, m_ms, m_to, p_cts, p_dsr, p_dcd, p_ri;
  int m_cnt;
  logic [7:0] m_iir;
  bit m_irq;

  always @(posedge clk) begin
    bit rdc, el, et, eo, em, ed, chg, restart;
    int code;
    if (rst) begin
      m_line = 0; m_tx = 0; m_ms = 0; m_to = 0; m_cnt = 0;
      m_iir = 8'h01; m_irq = 0;
    end else begin
      rdc = ien[0] && (fifo_en ? (rx_level != 0 && rx_level >= rx_thresh) : rx_full);
      el = m_line && ien[2];
      eo = m_to && ien[4] && fifo_en;
      et = m_tx && ien[1];
      em = m_ms && ien[3];
      ed = rdc;
      if (el) code = 6; else if (ed) code = 4; else if (eo) code = 12;
      else if (et) code = 2; else if (em) code = 0; else code = 1;
      if (ls_evt && ien[2]) m_line = 1; else if (rd_lsr) m_line = 0;
      if (tx_empty_evt && ien[1]) m_tx = 1;
      else if (wr_txd || (rd_iir && m_iir[3:0] == 4'd2)) m_tx = 0;
      chg = (cts != p_cts) || (dsr != p_dsr) || (dcd != p_dcd) || (p_ri && !ri);
      if (chg && ien[3]) m_ms = 1; else if (rd_msr) m_ms = 0;
      restart = !fifo_en || rx_level == 0 || rx_push || rd_rxd;
      if (restart) m_cnt = 0;
      else if (char_tick && m_cnt < TO_N) begin
        m_cnt++;
        if (m_cnt == TO_N && ien[4]) m_to = 1;
      end
      if (!restart && m_to && (rd_rxd || !fifo_en)) m_to = 0;
      if (rd_rxd || !fifo_en) m_to = 0;
      m_iir = {{2{fifo_en}}, 2'b00, 4'(code)};
      m_irq = el || ed || eo || et || em;
    end
    p_cts = cts; p_dsr = dsr; p_dcd = dcd; p_ri = ri;
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (iir !== m_iir) begin
        failures++;
        $display("FAIL R1 model compare iir act=%h exp=%h t=%0t", iir, m_iir, $time);
      end
      checks++;
      if (irq !== m_irq) begin
        failures++;
        $display("FAIL R2 model compare irq act=%0b exp=%0b t=%0t", irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] exp_iir, input logic exp_irq);
    checks++;
    if (iir !== exp_iir || irq !== exp_irq) begin
      failures++;
      $display("FAIL %s act=%h/%0b exp=%h/%0b t=%0t", req, iir, irq, exp_iir, exp_irq, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 ls,1 lsr,2 tx,3 wr,4 iir,5 msr,6 tick,7 push,8 rxd
  task automatic strobe(input int which);
    case (which)
      0: ls_evt = 1; 1: rd_lsr = 1; 2: tx_empty_evt = 1; 3: wr_txd = 1;
      4: rd_iir = 1; 5: rd_msr = 1; 6: char_tick = 1; 7: rx_push = 1;
      default: rd_rxd = 1;
    endcase
    @(negedge clk);
    ls_evt = 0; rd_lsr = 0; tx_empty_evt = 0; wr_txd = 0; rd_iir = 0;
    rd_msr = 0; char_tick = 0; rx_push = 0; rd_rxd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) strobe(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R2 reset state", 8'h01, 0);
    fifo_en = 1; cyc(1);
    chk("R3 fifo bits", 8'hC1, 0);

    strobe(2); cyc(1); chk("R7 tx raised", 8'hC2, 1);
    strobe(0); cyc(1); chk("R1 R4 line over tx", 8'hC6, 1);
    strobe(4); cyc(1); chk("R8 read while line on top keeps tx", 8'hC6, 1);
    strobe(1); cyc(1); chk("R4 R8 line cleared tx kept", 8'hC2, 1);
    strobe(4); cyc(1); chk("R8 read with tx on top clears", 8'hC1, 0);
    strobe(2); cyc(1); strobe(3); cyc(1); chk("R7 wr_txd clears", 8'hC1, 0);

    cts = 1; cyc(2); chk("R9 cts change", 8'hC0, 1);
    strobe(5); cyc(1); chk("R9 msr read clears", 8'hC1, 0);
    ri = 1; cyc(2); chk("R9 ri rise ignored", 8'hC1, 0);
    ri = 0; cyc(2); chk("R9 ri fall", 8'hC0, 1);
    strobe(5); cyc(1);

    rx_level = 3; cyc(1); chk("R5 below threshold", 8'hC1, 0);
    rx_level = 4; cyc(1); chk("R5 at threshold", 8'hC4, 1);
    rx_level = 2; cyc(1); chk("R5 level dropped", 8'hC1, 0);

    ticks(3); cyc(1); chk("R6 three ticks not yet", 8'hC1, 0);
    ticks(1); cyc(1); chk("R6 timeout after four", 8'hCC, 1);
    rx_level = 4; cyc(1); chk("R1 data above timeout", 8'hC4, 1);
    rx_level = 2; cyc(1); chk("R6 timeout still latched", 8'hCC, 1);
    strobe(8); cyc(1); chk("R6 rd_rxd clears", 8'hC1, 0);
    ticks(3); strobe(7); ticks(3); cyc(1); chk("R6 push restarts", 8'hC1, 0);
    ticks(1); cyc(1); chk("R6 four after push", 8'hCC, 1);
    strobe(8); cyc(1);
    rx_level = 0; ticks(6); cyc(1); chk("R6 empty holds count", 8'hC1, 0);

    ien = 5'h00; strobe(0); cyc(1); chk("R10 disabled event", 8'hC1, 0);
    ien = 5'h1F; cyc(2); chk("R10 disabled event dropped", 8'hC1, 0);
    strobe(0); cyc(1); chk("R10 enabled line", 8'hC6, 1);
    ien = 5'h1B; cyc(1); chk("R10 masked latched cause", 8'hC1, 0);
    ien = 5'h1F; cyc(1); chk("R10 unmasked again", 8'hC6, 1);
    strobe(1); cyc(1);

    fifo_en = 0; cyc(1); chk("R3 non-fifo bits", 8'h01, 0);
    rx_level = 8; cyc(1); chk("R5 level ignored non-fifo", 8'h01, 0);
    rx_level = 2; ticks(6); cyc(1); chk("R3 no timeout non-fifo", 8'h01, 0);
    rx_full = 1; cyc(1); chk("R5 holding full", 8'h04, 1);
    rx_full = 0; cyc(1);

    for (int i = 0; i < 4000; i++) begin
      ls_evt       = ($urandom % 23) == 0;
      rd_lsr       = ($urandom % 11) == 0;
      tx_empty_evt = ($urandom % 13) == 0;
      wr_txd       = ($urandom % 17) == 0;
      rd_iir       = ($urandom % 5) == 0;
      rd_msr       = ($urandom % 11) == 0;
      char_tick    = ($urandom % 3) == 0;
      rx_push      = ($urandom % 29) == 0;
      rd_rxd       = ($urandom % 31) == 0;
      if (($urandom % 19) == 0) cts = ~cts;
      if (($urandom % 23) == 0) ri = ~ri;
      if (($urandom % 37) == 0) dcd = ~dcd;
      if (($urandom % 41) == 0) dsr = ~dsr;
      if (($urandom % 13) == 0) rx_level = 5'($urandom % 9);
      if (($urandom % 97) == 0) fifo_en = ~fifo_en;
      if (($urandom % 61) == 0) ien = 5'($urandom);
      if (($urandom % 17) == 0) rx_full = ~rx_full;
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule